// File: doc/BRIEF.md
# Longest Prefix Match Lookup Engine

This block is a small forwarding table for 32-bit destination addresses. Each slot holds a valid flag, a prefix value, a prefix length and an outgoing port number. A write port loads one slot per cycle. A lookup request carries one address. The engine compares the address against every slot at once. Each slot checks only the most significant bits of the address, as many as its prefix length. When several slots match, the most specific one wins, which is the one with the longest prefix. The slot's position in the table does not decide the winner.

The result comes back on a fixed two-cycle pipeline with a strobe, and a new lookup can start every cycle. When no valid slot matches, the engine reports a miss with port zero. A parameter chooses how the winner is picked: a balanced comparison tree or a linear scan. Both give the same answer.

Top module: `lpm_lookup_engine`

## Requirements
- R1: After reset every slot is invalid, `rs_valid`, `rs_hit` and `rs_port` are 0, and any lookup reports a miss.
- R2: A slot matches when the top `len` bits of the address equal the top `len` bits of the slot's prefix. Prefix bits below the length are ignored.
- R3: A valid slot with length 0 matches every address.
- R4: When several valid slots match, the result is the port of the matching slot with the greatest length, whatever its index.
- R5: When the matching slots with the greatest length tie, the lowest-index slot among them wins.
- R6: A slot written with `wr_valid` = 0 never matches, even if it would be the longest match.
- R7: When no valid slot matches, `rs_hit` is 0 and `rs_port` is 0.
- R8: A request presented at rising edge N gives `rs_valid` = 1 with its result right after edge N+1. A cycle without a request gives `rs_valid` = 0 two edges later. Back-to-back requests give back-to-back results.
- R9: A write sampled at edge N is not seen by a lookup sampled at the same edge. It is seen by a lookup sampled at edge N+1 or later.
- R10: A written length greater than 32 is stored and matched as 32, so it needs an exact match of the full address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one slot |
| wr_idx | input | IDX_W (3) | Slot index to write |
| wr_valid | input | 1 | Valid flag stored in the slot |
| wr_prefix | input | ADDR_W (32) | Prefix value |
| wr_len | input | LEN_W (6) | Prefix length, 0 to 32 (larger values clamp to 32) |
| wr_port | input | PORT_W (4) | Outgoing port for the slot |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | ADDR_W (32) | Destination address to look up |
| rs_valid | output | 1 | Result strobe, two edges after the request |
| rs_hit | output | 1 | 1 when some valid slot matched |
| rs_port | output | PORT_W (4) | Port of the winning slot, 0 on a miss |

## Verification
The bench builds the engine with its defaults: 32-bit addresses, eight slots, 4-bit ports and the tree selector. Eight slots are enough for a default route, nested /8, /16, /21 and /32 prefixes, and two equal-length duplicates all at once, so every ordering case fits in one table. The 6-bit length field can carry values 33 to 63, which exercises the clamp. Random traffic draws addresses and prefixes from a few shared top-byte bases, so overlapping matches are frequent, and it mixes writes with lookups in the same cycle.

// File: rtl/lpm_pkg.sv
`timescale 1ns/1ps
package lpm_pkg;

   // Width needed to hold a prefix length from 0 to addr_w inclusive.
   function automatic int len_width(input int addr_w);
      return $clog2(addr_w + 1);
   endfunction

   // Width of a slot index; never below one bit.
   function automatic int idx_width(input int entries);
      return (entries > 1) ? $clog2(entries) : 1;
   endfunction

   // Structure used to pick the winning slot.
   typedef enum logic {
      SEL_SCAN = 1'b0,
      SEL_TREE = 1'b1
   } lpm_sel_e;

endpackage

// File: rtl/lpm_table.sv
`timescale 1ns/1ps
module lpm_table #(
   parameter int ADDR_W  = 32,
   parameter int ENTRIES = 8,
   parameter int PORT_W  = 4,
   parameter int LEN_W   = 6,
   parameter int IDX_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_prefix,
   input  logic [LEN_W-1:0]  wr_len,
   input  logic [PORT_W-1:0] wr_port,
   output logic [ENTRIES-1:0] tbl_valid,
   output logic [ADDR_W-1:0] tbl_prefix [ENTRIES],
   output logic [LEN_W-1:0]  tbl_len    [ENTRIES],
   output logic [PORT_W-1:0] tbl_port   [ENTRIES]
);

   localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(ADDR_W);

   logic [LEN_W-1:0] len_clamped;

   // Lengths beyond the address width collapse to a full-width match.
   assign len_clamped = (wr_len > FULL_LEN) ? FULL_LEN : wr_len;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
      logic              hit_wr;
      logic              v_q;
      logic [ADDR_W-1:0] p_q;
      logic [LEN_W-1:0]  l_q;
      logic [PORT_W-1:0] o_q;

      assign hit_wr = wr_en && (wr_idx == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            p_q <= '0;
            l_q <= '0;
            o_q <= '0;
         end else if (hit_wr) begin
            v_q <= wr_valid;
            p_q <= wr_prefix;
            l_q <= len_clamped;
            o_q <= wr_port;
         end
      end

      assign tbl_valid[e]  = v_q;
      assign tbl_prefix[e] = p_q;
      assign tbl_len[e]    = l_q;
      assign tbl_port[e]   = o_q;
   end

   // R9
   wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ({1'b0, wr_idx} < (IDX_W+1)'(ENTRIES)))
      |=> (tbl_valid[$past(wr_idx)] == $past(wr_valid)));

   // R10
   len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ({1'b0, wr_idx} < (IDX_W+1)'(ENTRIES)))
      |=> (tbl_len[$past(wr_idx)] <= FULL_LEN));

endmodule

// File: rtl/lpm_match.sv
`timescale 1ns/1ps
module lpm_match #(
   parameter int ADDR_W  = 32,
   parameter int ENTRIES = 8,
   parameter int LEN_W   = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  key,
   input  logic [ENTRIES-1:0] tbl_valid,
   input  logic [ADDR_W-1:0]  tbl_prefix [ENTRIES],
   input  logic [LEN_W-1:0]   tbl_len    [ENTRIES],
   output logic [ENTRIES-1:0] hit_vec
);

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      logic [ADDR_W-1:0] care;
      logic [ADDR_W-1:0] diff;

      // Bit b takes part when it lies within the top len bits.
      for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
         assign care[b] = (tbl_len[e] > LEN_W'(ADDR_W - 1 - b));
      end

      assign diff       = (key ^ tbl_prefix[e]) & care;
      assign hit_vec[e] = tbl_valid[e] && (diff == '0);

      // R3
      zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (tbl_valid[e] && (tbl_len[e] == '0)) |-> hit_vec[e]);
   end

endmodule

// File: rtl/lpm_select.sv
`timescale 1ns/1ps
module lpm_select #(
   parameter int ENTRIES = 8,
   parameter int PORT_W  = 4,
   parameter int LEN_W   = 6,
   parameter int IDX_W   = 3,
   parameter lpm_pkg::lpm_sel_e SEL_MODE = lpm_pkg::SEL_TREE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] hit_vec,
   input  logic [LEN_W-1:0]   tbl_len  [ENTRIES],
   input  logic [PORT_W-1:0]  tbl_port [ENTRIES],
   output logic               any_hit,
   output logic [PORT_W-1:0]  win_port
);

   logic              sel_hit;
   logic [IDX_W-1:0]  sel_idx;
   logic [ENTRIES-1:0] win_onehot;

   if (SEL_MODE == lpm_pkg::SEL_TREE) begin : g_tree
      localparam int LVL    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
      localparam int LEAVES = 1 << LVL;
      localparam int NODES  = 2 * LEAVES - 1;

      logic             nd_hit [NODES];
      logic [LEN_W-1:0] nd_len [NODES];
      logic [IDX_W-1:0] nd_idx [NODES];

      for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
         if (l < ENTRIES) begin : g_real
            assign nd_hit[LEAVES-1+l] = hit_vec[l];
            assign nd_len[LEAVES-1+l] = tbl_len[l];
            assign nd_idx[LEAVES-1+l] = IDX_W'(l);
         end else begin : g_pad
            assign nd_hit[LEAVES-1+l] = 1'b0;
            assign nd_len[LEAVES-1+l] = '0;
            assign nd_idx[LEAVES-1+l] = '0;
         end
      end

      // Left child always carries the lower indices, so it wins ties.
      for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
         logic take_l;
         assign take_l = nd_hit[2*k+1] &&
                         (!nd_hit[2*k+2] || (nd_len[2*k+1] >= nd_len[2*k+2]));
         assign nd_hit[k] = nd_hit[2*k+1] | nd_hit[2*k+2];
         assign nd_len[k] = take_l ? nd_len[2*k+1] : nd_len[2*k+2];
         assign nd_idx[k] = take_l ? nd_idx[2*k+1] : nd_idx[2*k+2];
      end

      assign sel_hit = nd_hit[0];
      assign sel_idx = nd_idx[0];
   end else begin : g_scan
      logic             sc_hit;
      logic [LEN_W-1:0] sc_len;
      logic [IDX_W-1:0] sc_idx;

      // Strictly-greater keeps the earliest slot on equal lengths.
      always_comb begin
         sc_hit = 1'b0;
         sc_len = '0;
         sc_idx = '0;
         for (int e = 0; e < ENTRIES; e++) begin
            if (hit_vec[e] && (!sc_hit || (tbl_len[e] > sc_len))) begin
               sc_hit = 1'b1;
               sc_len = tbl_len[e];
               sc_idx = IDX_W'(e);
            end
         end
      end

      assign sel_hit = sc_hit;
      assign sel_idx = sc_idx;
   end

   assign any_hit    = sel_hit;
   assign win_port   = sel_hit ? tbl_port[sel_idx] : '0;
   assign win_onehot = sel_hit ? (ENTRIES'(1) << sel_idx) : '0;

   // Independent scan: does any matching slot outrank the chosen one?
   logic beaten;
   always_comb begin
      beaten = 1'b0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (sel_hit && hit_vec[e]) begin
            if (tbl_len[e] > tbl_len[sel_idx]) beaten = 1'b1;
            if ((tbl_len[e] == tbl_len[sel_idx]) && (IDX_W'(e) < sel_idx)) beaten = 1'b1;
         end
      end
   end

   // R4
   pick_is_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|win_onehot) |-> (|(win_onehot & hit_vec)));

   // R4
   pick_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(win_onehot) && ((|hit_vec) == (|win_onehot)));

   // R5
   pick_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !beaten);

endmodule

// File: rtl/lpm_lookup_engine.sv
`timescale 1ns/1ps
module lpm_lookup_engine #(
   parameter int ADDR_W  = 32,
   parameter int ENTRIES = 8,
   parameter int PORT_W  = 4,
   parameter lpm_pkg::lpm_sel_e SEL_MODE = lpm_pkg::SEL_TREE,
   localparam int LEN_W  = lpm_pkg::len_width(ADDR_W),
   localparam int IDX_W  = lpm_pkg::idx_width(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_prefix,
   input  logic [LEN_W-1:0]  wr_len,
   input  logic [PORT_W-1:0] wr_port,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              rs_valid,
   output logic              rs_hit,
   output logic [PORT_W-1:0] rs_port
);

   if (ADDR_W < 1 || ADDR_W > 128) begin : g_bad_addr
      $error("lpm_lookup_engine: ADDR_W must lie in 1..128");
   end
   if (ENTRIES < 1 || ENTRIES > 1024) begin : g_bad_depth
      $error("lpm_lookup_engine: ENTRIES must lie in 1..1024");
   end
   if (PORT_W < 1) begin : g_bad_port
      $error("lpm_lookup_engine: PORT_W must be at least 1");
   end

   logic [ENTRIES-1:0] tbl_valid;
   logic [ADDR_W-1:0]  tbl_prefix [ENTRIES];
   logic [LEN_W-1:0]   tbl_len    [ENTRIES];
   logic [PORT_W-1:0]  tbl_port   [ENTRIES];
   logic [ENTRIES-1:0] hit_vec;
   logic               any_hit;
   logic [PORT_W-1:0]  win_port;

   lpm_table #(
      .ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .PORT_W(PORT_W),
      .LEN_W(LEN_W), .IDX_W(IDX_W)
   ) u_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
      .wr_prefix(wr_prefix), .wr_len(wr_len), .wr_port(wr_port),
      .tbl_valid(tbl_valid), .tbl_prefix(tbl_prefix),
      .tbl_len(tbl_len), .tbl_port(tbl_port)
   );

   lpm_match #(
      .ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .LEN_W(LEN_W)
   ) u_match (
      .clk(clk), .rst_n(rst_n),
      .key(lk_addr), .tbl_valid(tbl_valid),
      .tbl_prefix(tbl_prefix), .tbl_len(tbl_len),
      .hit_vec(hit_vec)
   );

   lpm_select #(
      .ENTRIES(ENTRIES), .PORT_W(PORT_W), .LEN_W(LEN_W),
      .IDX_W(IDX_W), .SEL_MODE(SEL_MODE)
   ) u_select (
      .clk(clk), .rst_n(rst_n),
      .hit_vec(hit_vec), .tbl_len(tbl_len), .tbl_port(tbl_port),
      .any_hit(any_hit), .win_port(win_port)
   );

   // Stage 1 captures the decision against the table as it stood
   // before this edge; stage 2 is the output register.
   logic              s1_valid;
   logic              s1_hit;
   logic [PORT_W-1:0] s1_port;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_hit   <= 1'b0;
         s1_port  <= '0;
         rs_valid <= 1'b0;
         rs_hit   <= 1'b0;
         rs_port  <= '0;
      end else begin
         s1_valid <= lk_valid;
         s1_hit   <= lk_valid && any_hit;
         s1_port  <= (lk_valid && any_hit) ? win_port : '0;
         rs_valid <= s1_valid;
         rs_hit   <= s1_valid && s1_hit;
         rs_port  <= s1_valid ? s1_port : '0;
      end
   end

   // R8
   lat_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> ##2 rs_valid);

   // R8
   lat_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> ##2 !rs_valid);

   // R7
   miss_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_valid && !rs_hit) |-> (rs_port == '0));

endmodule

// File: tb/lpm_lookup_engine_test.sv
`timescale 1ns/1ps
module lpm_lookup_engine_test;

   localparam int AW = 32;
   localparam int NE = 8;
   localparam int PW = 4;
   localparam int LW = 6;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [IW-1:0] wr_idx = '0;
   logic          wr_valid = 1'b0;
   logic [AW-1:0] wr_prefix = '0;
   logic [LW-1:0] wr_len = '0;
   logic [PW-1:0] wr_port = '0;
   logic          lk_valid = 1'b0;
   logic [AW-1:0] lk_addr = '0;
   logic          rs_valid;
   logic          rs_hit;
   logic [PW-1:0] rs_port;

   always #2.5 clk = ~clk;

   lpm_lookup_engine uut (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
      .wr_prefix(wr_prefix), .wr_len(wr_len), .wr_port(wr_port),
      .lk_valid(lk_valid), .lk_addr(lk_addr),
      .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_port(rs_port)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // Reference table kept by the bench.
   bit          m_v [NE];
   logic [31:0] m_p [NE];
   int          m_l [NE];
   int          m_o [NE];

   // Expected results in flight.
   bit    e1_v = 0, e2_v = 0;
   bit    e1_h = 0, e2_h = 0;
   int    e1_p = 0, e2_p = 0;
   string e1_t = "", e2_t = "";

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic bit slot_match(input logic [31:0] a, input int i);
      int l;
      if (!m_v[i]) return 1'b0;
      l = (m_l[i] > 32) ? 32 : m_l[i];
      if (l == 0) return 1'b1;
      return (a >> (32 - l)) == (m_p[i] >> (32 - l));
   endfunction

   task automatic predict(input logic [31:0] a, output bit h, output int p);
      int best;
      h = 1'b0; p = 0; best = -1;
      for (int i = 0; i < NE; i++) begin
         int l;
         l = (m_l[i] > 32) ? 32 : m_l[i];
         if (slot_match(a, i) && l > best) begin
            best = l; h = 1'b1; p = m_o[i];
         end
      end
   endtask

   // One cycle: check the result due now, drive new inputs, then advance.
   task automatic step(input bit we, input int wi, input bit wv,
                       input logic [31:0] wp, input int wl, input int wo,
                       input bit lv, input logic [31:0] la, input string tag);
      chk(rs_valid == e2_v, "R8", "rs_valid", rs_valid, e2_v);
      if (e2_v) begin
         chk(rs_hit == e2_h, e2_t, "rs_hit", rs_hit, e2_h);
         chk(rs_port == PW'(e2_p), e2_t, "rs_port", rs_port, e2_p);
      end
      e2_v = e1_v; e2_h = e1_h; e2_p = e1_p; e2_t = e1_t;
      wr_en = we; wr_idx = IW'(wi); wr_valid = wv; wr_prefix = wp;
      wr_len = LW'(wl); wr_port = PW'(wo);
      lk_valid = lv; lk_addr = la;
      e1_v = lv; e1_t = tag;
      if (lv) predict(la, e1_h, e1_p);
      else begin e1_h = 0; e1_p = 0; end
      if (we) begin
         m_v[wi] = wv; m_p[wi] = wp; m_l[wi] = wl; m_o[wi] = wo;
      end
      @(negedge clk);
   endtask

   task automatic wr(input int i, input bit v, input logic [31:0] p,
                     input int l, input int o);
      step(1, i, v, p, l, o, 0, 0, "");
   endtask

   task automatic lk(input logic [31:0] a, input string tag);
      step(0, 0, 0, 0, 0, 0, 1, a, tag);
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 0, 0, 0, "R8");
   endtask

   initial begin
      for (int i = 0; i < NE; i++) begin
         m_v[i] = 0; m_p[i] = 0; m_l[i] = 0; m_o[i] = 0;
      end
      repeat (4) @(negedge clk);
      chk(rs_valid == 1'b0, "R1", "reset rs_valid", rs_valid, 0);
      chk(rs_hit == 1'b0, "R1", "reset rs_hit", rs_hit, 0);
      chk(rs_port == '0, "R1", "reset rs_port", rs_port, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Empty table misses everywhere.
      lk(32'hFFFF_FFFF, "R1");
      lk(32'h0000_0000, "R1");
      idle();

      // Nested prefixes, longest at a higher index than shorter ones.
      wr(1, 1, 32'h8009_0000, 16, 1);
      wr(4, 1, 32'h8009_1000, 21, 7);
      wr(3, 1, 32'h414D_5863, 8, 3);      // low bits set below /8
      lk(32'h8009_100E, "R4");
      lk(32'h8009_C801, "R4");
      lk(32'h4101_0203, "R2");
      lk(32'h0A00_0001, "R7");
      lk(32'h8109_100E, "R7");
      idle();

      // Default route.
      wr(7, 1, 32'hDEAD_BEEF, 0, 9);
      lk(32'h0A00_0001, "R3");
      lk(32'h8009_100E, "R4");

      // Equal-length duplicates, then invalidate the winner.
      wr(5, 1, 32'hC801_0000, 16, 5);
      wr(6, 1, 32'hC801_0000, 16, 6);
      lk(32'hC801_0203, "R5");
      wr(5, 0, 32'hC801_0200, 24, 12);    // invalid but longer
      lk(32'hC801_0203, "R6");

      // Write and lookup in the same cycle, then the cycle after.
      step(1, 0, 1, 32'h0B00_0000, 8, 2, 1, 32'h0B01_0101, "R9");
      lk(32'h0B01_0101, "R9");

      // Over-long length clamps to a full match.
      wr(2, 1, 32'h0102_0304, 40, 4);
      lk(32'h0102_0304, "R10");
      lk(32'h0102_0305, "R10");
      wr(2, 1, 32'h0102_0304, 32, 8);
      lk(32'h0102_0304, "R10");
      idle(); idle();

      // Constrained random traffic over shared top bytes.
      begin
         logic [31:0] bases [4];
         int unsigned seed;
         bases[0] = 32'h8009_0000; bases[1] = 32'h4100_0000;
         bases[2] = 32'hC801_0000; bases[3] = 32'h0A00_0000;
         seed = $urandom(32'd20240611);
         for (int n = 0; n < 4000; n++) begin
            bit          we, wv, lv;
            int          wi, wl, wo;
            logic [31:0] wp, la;
            we = ($urandom % 4) == 0;
            wi = int'($urandom % NE);
            wv = ($urandom % 8) != 0;
            wp = bases[$urandom % 4] | ($urandom & 32'h0000_FFFF);
            wl = int'($urandom % 34);
            wo = int'($urandom % 16);
            lv = ($urandom % 5) != 0;
            la = bases[$urandom % 4] | ($urandom & 32'h0000_FFFF);
            step(we, wi, wv, wp, wl, wo, lv, la, "R4");
         end
      end
      idle(); idle(); idle();

      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(5 * 150000);
      if (!finished) begin
         finished = 1'b1;
         checks++; errors++;
         $display("FAIL R8 watchdog: actual %0h expected %0h", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule